// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of an all-digital PLL. It counts rollover pulses from the phase accumulator of the numerically controlled oscillator and produces one feedback event for every S + 1 + U/V pulses on average. It reaches the fractional average by stretching some periods to S + 2 pulses and leaving the rest at S + 1. A modulo-V accumulator, which adds U once per output period, decides which periods are stretched.

The stretching is deterministic, so the block does not leave it to appear as spurs. With every event it exports a residual phase word: the accumulator contents, in units of 1/V of one rollover period. This is exactly how far the actual feedback edge runs ahead of the ideal fractional edge. A downstream digital phase detector adds the word to its measurement and so cancels the modulation.

The configuration inputs are sampled only when a new output period begins. A period that has already started always runs to its full length.

Top module: `fracn_fb_divider`

## Requirements
- R1: While reset is asserted, and until the first event after reset, `fb_stb_o` is 0 and `fb_res_o` is 0.
- R2: When the fraction is disabled, the block emits exactly one event for every S + 1 counted rollover pulses.
- R3: An integer setting S below 7 is treated as 7, giving periods of 8 pulses.
- R4: When 0 < U < V, each new period first adds U to the accumulator. If the sum reaches V, V is subtracted and the period lasts S + 2 pulses; otherwise it lasts S + 1 pulses.
- R5: `fb_stb_o` is high for the single cycle after the clock edge that samples the last rollover pulse of a period. In that same cycle `fb_res_o` carries the accumulator value that was set at the start of the period just ended, as a non-negative two's-complement word in units of 1/V of a rollover period. `fb_res_o` holds this value until the next event.
- R6: When U is 0, or when U is not less than V, the fraction has no effect. Every period lasts S + 1 pulses, the accumulator is cleared, and the residual of the following event is 0.
- R7: S, U and V are sampled only on the clock edge that ends a period, which is the same edge that samples its last pulse. Changes at any other time have no effect on the period in progress.
- R8: After reset is released, rollover pulses on the first three rising edges are ignored. The configuration present at the third edge sets the first period.
- R9: A rollover pulse on the edge that ends a period is consumed by that period. The next pulse is the first one counted in the new period, so pulses arriving on every cycle lose no count.
- R10: If, at the start of a period, the accumulator value is not less than the newly sampled V, the accumulator restarts from 0 before U is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| roll_i | input | 1 | One-cycle rollover pulse from the phase accumulator |
| div_int_i | input | INT_W | Integer part S of the ratio |
| frac_num_i | input | FRAC_W | Fraction numerator U |
| frac_den_i | input | FRAC_W | Fraction denominator V |
| fb_stb_o | output | 1 | Feedback event strobe, one cycle wide |
| fb_res_o | output | FRAC_W+1 | Signed residual phase word in units of 1/V of a rollover period |

## Verification
The closing of one period and the opening of the next fall on the same clock edge. On that edge the last rollover pulse is consumed, the residual is captured, and the new S, U and V are sampled. This edge is provoked in two ways: by driving rollover pulses on every cycle, and by changing the configuration on random cycles, including the cycle that ends a period. A behavioural model in the bench, written with integers, predicts the strobe and the residual for every clock. The model's predictions are compared with the outputs on every cycle, so a pulse that is lost or counted twice on the boundary, or a configuration that is taken up too early, shows as a mismatch.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int unsigned DEF_INT_W  = 30;
  localparam int unsigned DEF_FRAC_W = 10;
  localparam int unsigned MIN_INT    = 7;
endpackage

// File: rtl/fnd_frac_accum.sv
module fnd_frac_accum #(
  parameter int unsigned FRAC_W = fnd_pkg::DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] u_i,
  input  logic [FRAC_W-1:0] v_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              ovf_o
);
  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q, acc_d, base;
  logic [SUM_W-1:0]  sum, wrapped;

  always_comb begin
    base    = (acc_q < v_i) ? acc_q : '0;
    sum     = {1'b0, base} + {1'b0, u_i};
    wrapped = sum - {1'b0, v_i};
    ovf_o   = en_i && (sum >= {1'b0, v_i});
    acc_d   = acc_q;
    if (adv_i) begin
      if (!en_i)      acc_d = '0;
      else if (ovf_o) acc_d = wrapped[FRAC_W-1:0];
      else            acc_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R4, R10: the accumulator stays below the denominator it was last advanced with
  p_acc_below_v_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && en_i) |=> (acc_q < $past(v_i)));

  // R6: a disabled fraction leaves the accumulator cleared
  p_acc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !en_i) |=> (acc_q == '0));
endmodule

// File: rtl/fnd_period_counter.sv
module fnd_period_counter #(
  parameter int unsigned CNT_W = fnd_pkg::DEF_INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_m1_i,
  input  logic             tick_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len_m1_q, len_m1_d;

  assign hit_o = tick_i && (cnt_q == len_m1_q);

  always_comb begin
    cnt_d    = cnt_q;
    len_m1_d = len_m1_q;
    if (load_i) begin
      cnt_d    = '0;
      len_m1_d = len_m1_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      len_m1_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      len_m1_q <= len_m1_d;
    end
  end

  // R2: the count never passes the period's final value
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_m1_q);

  // R9: a new period always starts counting from zero
  p_restart_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider #(
  parameter int unsigned INT_W  = fnd_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fnd_pkg::DEF_FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     roll_i,
  input  logic [INT_W-1:0]         div_int_i,
  input  logic [FRAC_W-1:0]        frac_num_i,
  input  logic [FRAC_W-1:0]        frac_den_i,
  output logic                     fb_stb_o,
  output logic signed [FRAC_W:0]   fb_res_o
);
  localparam int unsigned CNT_W = INT_W + 1;
  localparam int unsigned RES_W = FRAC_W + 1;
  localparam logic [INT_W-1:0] S_MIN = INT_W'(fnd_pkg::MIN_INT);

  logic rst_meta_q, rst_sync_q;
  logic armed_q;
  logic frac_en, ovf, hit, load, tick;
  logic [INT_W-1:0]  s_eff;
  logic [CNT_W-1:0]  len_m1;
  logic [FRAC_W-1:0] acc;
  logic              stb_d;
  logic [RES_W-1:0]  res_q, res_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    frac_en = (frac_num_i != '0) && (frac_num_i < frac_den_i);
    s_eff   = (div_int_i < S_MIN) ? S_MIN : div_int_i;
    len_m1  = {1'b0, s_eff} + {{(CNT_W-1){1'b0}}, ovf};
    tick    = armed_q && roll_i;
    load    = hit || !armed_q;
    stb_d   = hit;
    res_d   = hit ? {1'b0, acc} : res_q;
  end

  fnd_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .adv_i  (load),
    .en_i   (frac_en),
    .u_i    (frac_num_i),
    .v_i    (frac_den_i),
    .acc_o  (acc),
    .ovf_o  (ovf)
  );

  fnd_period_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .load_i   (load),
    .len_m1_i (len_m1),
    .tick_i   (tick),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      armed_q  <= 1'b0;
      fb_stb_o <= 1'b0;
      res_q    <= '0;
    end else begin
      armed_q  <= 1'b1;
      fb_stb_o <= stb_d;
      res_q    <= res_d;
    end
  end

  assign fb_res_o = $signed(res_q);

  // R5: the strobe is a single cycle wide
  p_stb_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    fb_stb_o |=> !fb_stb_o);

  // R5: the residual word is never negative
  p_res_nonneg_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !fb_res_o[FRAC_W]);

  // R8: the arming edge produces no event
  p_no_stb_arming_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !armed_q |=> !fb_stb_o);

  // R5: the residual only moves together with a strobe
  p_res_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !fb_stb_o |-> $stable(fb_res_o));
endmodule

// File: tb/fracn_fb_divider_tb_top.sv
module fracn_fb_divider_tb_top;
  localparam int unsigned INT_W  = 30;
  localparam int unsigned FRAC_W = 10;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   roll = 1'b0;
  logic [INT_W-1:0]       s_cfg = '0;
  logic [FRAC_W-1:0]      u_cfg = '0;
  logic [FRAC_W-1:0]      v_cfg = '0;
  logic                   stb;
  logic signed [FRAC_W:0] res;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  fracn_fb_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .roll_i(roll),
    .div_int_i(s_cfg), .frac_num_i(u_cfg), .frac_den_i(v_cfg),
    .fb_stb_o(stb), .fb_res_o(res)
  );

  // behavioural reference model
  int      m_edges;
  bit      m_armed;
  longint  m_cnt, m_len, m_acc;
  bit      m_stb;
  longint  m_res;

  task automatic m_start();
    longint s, u, v, base, sum;
    s = s_cfg; u = u_cfg; v = v_cfg;
    if (s < 7) s = 7;
    m_cnt = 0;
    if (u == 0 || u >= v) begin
      m_acc = 0;
      m_len = s + 1;
    end else begin
      base = (m_acc < v) ? m_acc : 0;
      sum  = base + u;
      if (sum >= v) begin m_acc = sum - v; m_len = s + 2; end
      else          begin m_acc = sum;     m_len = s + 1; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_armed = 0; m_cnt = 0; m_len = 0;
      m_acc = 0; m_stb = 0; m_res = 0;
    end else if (m_edges < 2) begin
      m_edges++;
    end else if (!m_armed) begin
      m_start();
      m_armed = 1;
    end else begin
      m_stb = 0;
      if (roll) begin
        if (m_cnt == m_len - 1) begin
          m_stb = 1;
          m_res = m_acc;
          m_start();
        end else begin
          m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (stb !== m_stb) begin
        failures++;
        $display("FAIL %s strobe actual=%0b expected=%0b t=%0t", cur_req, stb, m_stb, $time);
      end
      checks++;
      if (longint'(res) != m_res || $isunknown(res)) begin
        failures++;
        $display("FAIL %s residual actual=%0d expected=%0d t=%0t", cur_req, res, m_res, $time);
      end
    end
  end

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      roll = (($urandom % 100) < pct);
    end
  endtask

  task automatic set_cfg(input int s, input int u, input int v);
    @(negedge clk);
    s_cfg = INT_W'(s); u_cfg = FRAC_W'(u); v_cfg = FRAC_W'(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    s_cfg = INT_W'(7); u_cfg = '0; v_cfg = '0;
    repeat (4) @(negedge clk);
    // R8: rollover held high from the release on
    cur_req = "R8";
    rst_n = 1'b1;
    roll  = 1'b1;
    repeat (40) @(negedge clk);
    // R3: S below the minimum
    cur_req = "R3";
    set_cfg(3, 0, 0);  run(60, 100);
    set_cfg(0, 0, 0);  run(60, 70);
    // R2: integer division under sparse and dense pulses
    cur_req = "R2";
    set_cfg(12, 0, 0); run(300, 30);
    set_cfg(9, 0, 0);  run(300, 90);
    // R4 / R5: fractional division
    cur_req = "R4";
    set_cfg(8, 3, 7);  run(2000, 50);
    cur_req = "R5";
    set_cfg(7, 999, 1000); run(3000, 100);
    // R6: fraction disabled by value
    cur_req = "R6";
    set_cfg(10, 7, 7); run(300, 60);
    set_cfg(10, 9, 5); run(300, 60);
    set_cfg(10, 0, 4); run(300, 60);
    // R10: stale accumulator larger than a new denominator
    cur_req = "R10";
    set_cfg(7, 999, 1000); run(400, 100);
    set_cfg(7, 2, 5);      run(400, 100);
    // R7 / R9: random configuration on random cycles, pulses every cycle
    cur_req = "R7";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      roll = 1'b1;
      if (($urandom % 5) == 0) begin
        s_cfg = INT_W'($urandom % 16);
        v_cfg = FRAC_W'($urandom % 12);
        u_cfg = FRAC_W'($urandom % 12);
      end
      repeat (5) @(negedge clk);
    end
    cur_req = "R9";
    set_cfg(7, 1, 2); run(2000, 100);
    set_cfg(8, 5, 9); run(2000, 100);
    // R1: asynchronous reset mid-run
    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R8";
    run(200, 80);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule